// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block turns an asynchronous serial line into bytes. It samples the line only in cycles where a one-cycle enable pulse is high. That enable runs at sixteen times the bit rate. A falling edge that is still low half a bit later starts a character. The data bits, the optional parity bit and the stop bits are then each sampled in the middle of their bit period. Word length, parity mode and stop length are inputs that the transmit side also uses. They must be held steady while a character is being received.

Each finished character is pushed into a receive queue together with three flags: parity, framing and break. The surrounding logic reads the queue with a read strobe. The byte at the head of the queue and its flags are always visible on the outputs.

The block also keeps:
- a sticky overrun flag;
- a global error flag, high while any queued character carries an error;
- a saturating count of 16x ticks since the last receive or read;
- a character-timeout flag derived from that count and scaled to the word length.

Top module: `serial_rx_core`

## Requirements
- R1: Data bits arrive least significant bit first. `word_len` code 0, 1, 2 and 3 selects 8, 7, 6 and 5 data bits. Unused upper bits of `rd_data` read 0.
- R2: A start is recognised when a tick finds the line low after a tick that found it high. It is confirmed only if the line is still low on the 8th tick after that. A low pulse shorter than this queues nothing.
- R3: `parity_mode[0]`=1 adds one parity bit after the data. `parity_mode[2:1]` selects the mode: 00 odd, 01 even, 10 always 1, 11 always 0. `err_parity` is set when the received bit differs from the expected value. With `parity_mode[0]`=0 there is no parity bit and `err_parity` stays 0.
- R4: `stop_half` gives the stop length in half bits. Values 2 and 3 sample one stop bit; 4 samples two. `err_frame` is set if any stop sample is low.
- R5: `err_break` is set when every sample of the frame is low: start, data, parity and stop. Such a character also has `err_frame` set.
- R6: The queue is first in, first out. `q_count` holds the number of entries, `q_empty` is high at 0 and `q_full` is high at DEPTH. `rd_stb` while empty changes nothing.
- R7: A character that completes while the queue is full is dropped and sets `err_overrun`. The flag stays set until `q_clear`.
- R8: `err_any` is high while at least one queued character has a parity, framing or break flag. The head flags read 0 when the queue is empty.
- R9: `idle_ticks` counts tick pulses and saturates at its maximum. It returns to 0 when a character completes or when a read pops a non-empty queue.
- R10: `char_timeout` is set when `idle_ticks`/16 reaches at least 4 × data bits + 12 while the queue is non-empty. It is cleared by `rd_stb`.
- R11: `q_clear` empties the queue and clears `err_overrun` and `err_any`. It takes priority over a character that completes in the same cycle.
- R12: After reset the queue is empty and not full, all flags are 0, `idle_ticks` is 0 and `char_timeout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Sampling enable at 16x bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| word_len | input | 2 | Data bit count code (0=8 .. 3=5) |
| parity_mode | input | 3 | Parity enable and mode |
| stop_half | input | 3 | Stop length in half bits (2, 3, 4) |
| rd_stb | input | 1 | Pop the head of the queue |
| q_clear | input | 1 | Empty the queue and clear queue errors |
| rd_data | output | 8 | Head character |
| q_empty | output | 1 | Queue holds no character |
| q_full | output | 1 | Queue holds DEPTH characters |
| q_count | output | $clog2(DEPTH)+1 | Number of queued characters |
| err_parity | output | 1 | Head character parity error |
| err_frame | output | 1 | Head character framing error |
| err_overrun | output | 1 | Sticky overrun flag |
| err_break | output | 1 | Head character is a break |
| err_any | output | 1 | Some queued character carries an error |
| idle_ticks | output | IW | Saturating tick count since last receive or read |
| char_timeout | output | 1 | Character timeout |

## Verification
The hardest situation to reach from the ports is a character with an error sitting behind a good one, so that `err_any` must stay high while the head flags are clear. It must then drop only when the faulty entry leaves. The stimulus queues a good byte, a byte with a flipped parity bit and another good byte, and pops them one at a time. Overrun is reached by shrinking the queue to four entries and sending a fifth character. The timeout threshold is measured by polling the first cycle in which `char_timeout` rises and comparing `idle_ticks`/16 against 4 × bits + 12 for two word lengths.

// File: rtl/rx_core_pkg.sv
package rx_core_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } fr_state_e;

    // one queued character with its per-character flags
    typedef struct packed {
        logic              brk;
        logic              frame;
        logic              parity;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // frame sequencer state
    typedef struct packed {
        fr_state_e         st;
        logic [3:0]        tcnt;
        logic [2:0]        bidx;
        logic [1:0]        stops;
        logic [CHAR_W-1:0] data;
        logic              all_low;
        logic              ferr;
        logic              perr;
        logic              line_prev;
        logic              done;
    } fr_state_t;

    // number of data bits for a word-length code
    function automatic logic [3:0] bits_of(input logic [1:0] code);
        return 4'd8 - {2'b00, code};
    endfunction

    // expected parity bit for the selected mode over the active data bits
    function automatic logic parity_of(input logic [1:0] kind,
                                       input logic [CHAR_W-1:0] d,
                                       input logic [1:0] code);
        logic [CHAR_W-1:0] dm;
        dm = d & (8'hFF >> code);
        case (kind)
            2'b00:   return ~^dm;
            2'b01:   return ^dm;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_core_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  logic [1:0] word_len,
    input  logic [2:0] parity_mode,
    input  logic [2:0] stop_half,
    output logic      done,
    output rx_entry_t entry
);
    fr_state_t  st_d, st_q;
    logic [2:0] last_idx;
    logic [1:0] stop_cnt;

    assign last_idx = 3'd7 - {1'b0, word_len};
    assign stop_cnt = (stop_half >= 3'd4) ? 2'd2 : 2'd1;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (tick) begin
            st_d.line_prev = line;
            case (st_q.st)
                FR_IDLE: begin
                    if (st_q.line_prev && !line) begin
                        st_d.st   = FR_START;
                        st_d.tcnt = 4'd0;
                    end
                end
                FR_START: begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                    if (st_q.tcnt == 4'd7) begin
                        if (!line) begin
                            st_d.st      = FR_DATA;
                            st_d.tcnt    = 4'd0;
                            st_d.bidx    = 3'd0;
                            st_d.data    = '0;
                            st_d.all_low = 1'b1;
                            st_d.ferr    = 1'b0;
                            st_d.perr    = 1'b0;
                        end else begin
                            st_d.st = FR_IDLE;
                        end
                    end
                end
                FR_DATA: begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                    if (st_q.tcnt == 4'd15) begin
                        st_d.data[st_q.bidx] = line;
                        st_d.all_low         = st_q.all_low & ~line;
                        st_d.bidx            = st_q.bidx + 3'd1;
                        if (st_q.bidx == last_idx) begin
                            st_d.st    = parity_mode[0] ? FR_PARITY : FR_STOP;
                            st_d.stops = stop_cnt;
                        end
                    end
                end
                FR_PARITY: begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                    if (st_q.tcnt == 4'd15) begin
                        st_d.perr    = line != parity_of(parity_mode[2:1], st_q.data, word_len);
                        st_d.all_low = st_q.all_low & ~line;
                        st_d.st      = FR_STOP;
                    end
                end
                FR_STOP: begin
                    st_d.tcnt = st_q.tcnt + 4'd1;
                    if (st_q.tcnt == 4'd15) begin
                        st_d.ferr    = st_q.ferr | ~line;
                        st_d.all_low = st_q.all_low & ~line;
                        st_d.stops   = st_q.stops - 2'd1;
                        if (st_q.stops == 2'd1) begin
                            st_d.st   = FR_IDLE;
                            st_d.done = 1'b1;
                        end
                    end
                end
                default: st_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= '0;
            st_q.line_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done         = st_q.done;
    assign entry.brk    = st_q.all_low;
    assign entry.frame  = st_q.ferr;
    assign entry.parity = st_q.perr;
    assign entry.data   = st_q.data;
endmodule

// File: rtl/rx_queue.sv
module rx_queue
    import rx_core_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  rx_entry_t                push_entry,
    input  logic                     pop,
    input  logic                     clear,
    output rx_entry_t                head,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     overrun,
    output logic                     any_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [CW-1:0] errs;
        logic          ovr;
    } q_state_t;

    q_state_t  qs_d, qs_q;
    rx_entry_t mem [DEPTH];
    logic      do_push, do_pop, push_bad, head_bad;

    assign empty    = qs_q.cnt == '0;
    assign full     = qs_q.cnt == CW'(DEPTH);
    assign head     = mem[qs_q.rp];
    assign do_push  = push && !full && !clear;
    assign do_pop   = pop && !empty && !clear;
    assign push_bad = push_entry.brk | push_entry.frame | push_entry.parity;
    assign head_bad = head.brk | head.frame | head.parity;

    always_comb begin
        qs_d = qs_q;
        if (clear) begin
            qs_d = '0;
        end else begin
            if (push && full) qs_d.ovr = 1'b1;
            if (do_push) qs_d.wp = (qs_q.wp == LAST) ? '0 : qs_q.wp + 1'b1;
            if (do_pop)  qs_d.rp = (qs_q.rp == LAST) ? '0 : qs_q.rp + 1'b1;
            qs_d.cnt  = qs_q.cnt + CW'(do_push) - CW'(do_pop);
            qs_d.errs = qs_q.errs + CW'(do_push && push_bad) - CW'(do_pop && head_bad);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) qs_q <= '0;
        else     qs_q <= qs_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[qs_q.wp] <= push_entry;
    end

    assign count   = qs_q.cnt;
    assign overrun = qs_q.ovr;
    assign any_err = qs_q.errs != '0;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_core_pkg::*;
#(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic          rd_stb,
    input  logic          q_empty,
    input  logic [1:0]    word_len,
    output logic [IW-1:0] idle_ticks,
    output logic          timeout
);
    typedef struct packed {
        logic [IW-1:0] idle;
        logic          tout;
    } tm_state_t;

    tm_state_t     tm_d, tm_q;
    logic [6:0]    limit_bits;
    logic          reached;

    assign limit_bits = {1'b0, bits_of(word_len), 2'b00} + 7'd12;
    assign reached    = (tm_q.idle >> 4) >= IW'(limit_bits);

    always_comb begin
        tm_d = tm_q;
        if (restart || (rd_stb && !q_empty))
            tm_d.idle = '0;
        else if (tick && tm_q.idle != '1)
            tm_d.idle = tm_q.idle + 1'b1;

        if (rd_stb)
            tm_d.tout = 1'b0;
        else if (!q_empty && reached)
            tm_d.tout = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= '0;
        else     tm_q <= tm_d;
    end

    assign idle_ticks = tm_q.idle;
    assign timeout    = tm_q.tout;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import rx_core_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int IW          = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick16,
    input  logic                   rxd,
    input  logic [1:0]             word_len,
    input  logic [2:0]             parity_mode,
    input  logic [2:0]             stop_half,
    input  logic                   rd_stb,
    input  logic                   q_clear,
    output logic [7:0]             rd_data,
    output logic                   q_empty,
    output logic                   q_full,
    output logic [$clog2(DEPTH):0] q_count,
    output logic                   err_parity,
    output logic                   err_frame,
    output logic                   err_overrun,
    output logic                   err_break,
    output logic                   err_any,
    output logic [IW-1:0]          idle_ticks,
    output logic                   char_timeout
);
    logic      line_s;
    logic      frm_done;
    rx_entry_t frm_entry;
    rx_entry_t head;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s)
    );

    rx_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick16),
        .line        (line_s),
        .word_len    (word_len),
        .parity_mode (parity_mode),
        .stop_half   (stop_half),
        .done        (frm_done),
        .entry       (frm_entry)
    );

    rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (frm_done),
        .push_entry (frm_entry),
        .pop        (rd_stb),
        .clear      (q_clear),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full),
        .count      (q_count),
        .overrun    (err_overrun),
        .any_err    (err_any)
    );

    rx_idle_timer #(.IW(IW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .restart    (frm_done),
        .rd_stb     (rd_stb),
        .q_empty    (q_empty),
        .word_len   (word_len),
        .idle_ticks (idle_ticks),
        .timeout    (char_timeout)
    );

    assign rd_data    = q_empty ? '0 : head.data;
    assign err_parity = !q_empty && head.parity;
    assign err_frame  = !q_empty && head.frame;
    assign err_break  = !q_empty && head.brk;
endmodule

// File: rtl/serial_rx_core_checker.sv
module serial_rx_core_checker #(
    parameter int DEPTH = 16,
    parameter int IW    = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rd_stb,
    input logic                   q_clear,
    input logic                   frm_done,
    input logic                   q_empty,
    input logic                   q_full,
    input logic [$clog2(DEPTH):0] q_count,
    input logic                   err_overrun,
    input logic                   err_any,
    input logic                   err_parity,
    input logic                   err_frame,
    input logic                   err_break,
    input logic [IW-1:0]          idle_ticks,
    input logic                   char_timeout
);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        q_count <= ($clog2(DEPTH)+1)'(DEPTH));

    a_r6_flags_track_count: assert property (@(posedge clk) disable iff (rst)
        (q_empty == (q_count == '0)) && !(q_empty && q_full));

    a_r6_pop_empty_no_change: assert property (@(posedge clk) disable iff (rst)
        (q_empty && !frm_done) |=> q_empty);

    a_r7_overrun_on_full: assert property (@(posedge clk) disable iff (rst)
        (frm_done && q_full && !q_clear) |=> err_overrun);

    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !q_clear) |=> err_overrun);

    a_r8_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
        q_empty |-> !(err_any || err_parity || err_frame || err_break));

    a_r9_restart_on_char: assert property (@(posedge clk) disable iff (rst)
        frm_done |=> idle_ticks == '0);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !char_timeout);

    a_r10_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(char_timeout) |-> $past(!q_empty));

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        q_clear |=> (q_empty && !err_overrun && !err_any));
endmodule

bind serial_rx_core serial_rx_core_checker #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_stb       (rd_stb),
    .q_clear      (q_clear),
    .frm_done     (frm_done),
    .q_empty      (q_empty),
    .q_full       (q_full),
    .q_count      (q_count),
    .err_overrun  (err_overrun),
    .err_any      (err_any),
    .err_parity   (err_parity),
    .err_frame    (err_frame),
    .err_break    (err_break),
    .idle_ticks   (idle_ticks),
    .char_timeout (char_timeout)
);

// File: tb/serial_rx_core_test.sv
`timescale 1ns/1ps
module serial_rx_core_test;
    localparam int TDIV    = 2;
    localparam int BIT_CYC = 16 * TDIV;
    localparam int DEPTH   = 4;
    localparam int IW      = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick16;
    logic rxd = 1'b1;
    logic [1:0] word_len = 2'd0;
    logic [2:0] parity_mode = 3'd0;
    logic [2:0] stop_half = 3'd2;
    logic rd_stb = 1'b0;
    logic q_clear = 1'b0;
    logic [7:0] rd_data;
    logic q_empty, q_full;
    logic [$clog2(DEPTH):0] q_count;
    logic err_parity, err_frame, err_overrun, err_break, err_any;
    logic [IW-1:0] idle_ticks;
    logic char_timeout;

    int n_chk = 0;
    int n_bad = 0;
    int tdc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) tdc <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    assign tick16 = !rst && (tdc == 0);

    serial_rx_core #(.DEPTH(DEPTH), .IW(IW)) uut (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .word_len(word_len), .parity_mode(parity_mode), .stop_half(stop_half),
        .rd_stb(rd_stb), .q_clear(q_clear), .rd_data(rd_data),
        .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .err_break(err_break), .err_any(err_any), .idle_ticks(idle_ticks),
        .char_timeout(char_timeout)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int halves);
        rxd = v;
        repeat (halves * BIT_CYC / 2) @(negedge clk);
    endtask

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] wl, input logic [2:0] pm);
        logic [7:0] dm;
        dm = d & (8'hFF >> wl);
        case (pm[2:1])
            2'b00:   return ~^dm;
            2'b01:   return ^dm;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // start, data LSB first, optional parity (optionally flipped), stop levels, one idle bit
    task automatic send(input logic [7:0] d, input logic flip, input logic [1:0] stops);
        int nb;
        nb = 8 - int'(word_len);
        hold(1'b0, 2);
        for (int i = 0; i < nb; i++) hold(d[i], 2);
        if (parity_mode[0]) hold(par_bit(d, word_len, parity_mode) ^ flip, 2);
        hold(stops[0], 2);
        if (stop_half == 3'd3) hold(1'b1, 1);
        else if (stop_half >= 3'd4) hold(stops[1], 2);
        hold(1'b1, 2);
    endtask

    task automatic pop();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic clear_q();
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
    endtask

    task automatic expect_head(input string tag, input logic [7:0] d,
                               input logic b, input logic f, input logic p);
        logic [7:0] dm;
        dm = d & (8'hFF >> word_len);
        chk(tag, {21'd0, err_break, err_frame, err_parity, rd_data},
                 {21'd0, b, f, p, dm});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        logic [2:0] modes [5];
        bit found;
        int seen;
        pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h01;
        modes[0] = 3'b000; modes[1] = 3'b001; modes[2] = 3'b011;
        modes[3] = 3'b101; modes[4] = 3'b111;

        repeat (4) @(negedge clk);
        // R12 reset state
        chk("R12 reset flags", {27'd0, q_empty, q_full, err_overrun, err_any, char_timeout},
            {27'd0, 5'b10000});
        chk("R12 reset count/idle", {16'd0, 4'(q_count), idle_ticks}, 32'd0);
        chk("R12 reset head flags", {29'd0, err_parity, err_frame, err_break}, 32'd0);
        rst = 1'b0;
        repeat (8) @(negedge clk);

        // R1 full sweep of 8 data bits, no parity, one stop
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 1'b0, 2'b11);
            expect_head("R1 8N1 data", 8'(v), 1'b0, 1'b0, 1'b0);
            chk("R6 one entry", 32'(q_count), 32'd1);
            pop();
        end

        // R1/R3 word lengths x parity modes
        for (int w = 0; w < 4; w++) begin
            for (int m = 0; m < 5; m++) begin
                for (int k = 0; k < 4; k++) begin
                    word_len = 2'(w);
                    parity_mode = modes[m];
                    send(pats[k], 1'b0, 2'b11);
                    expect_head("R3 format sweep", pats[k], 1'b0, 1'b0, 1'b0);
                    pop();
                end
            end
        end
        word_len = 2'd0;
        parity_mode = 3'b000;

        // R2 short low glitch is ignored
        clear_q();
        rxd = 1'b0;
        repeat (4 * TDIV) @(negedge clk);
        hold(1'b1, 4);
        chk("R2 glitch ignored", 32'(q_empty), 32'd1);
        send(8'h96, 1'b0, 2'b11);
        expect_head("R2 recovery after glitch", 8'h96, 1'b0, 1'b0, 1'b0);
        pop();

        // R3 parity errors
        parity_mode = 3'b011;
        send(8'h35, 1'b1, 2'b11);
        expect_head("R3 even parity error", 8'h35, 1'b0, 1'b0, 1'b1);
        chk("R8 error char sets err_any", 32'(err_any), 32'd1);
        pop();
        parity_mode = 3'b001;
        send(8'hE0, 1'b1, 2'b11);
        expect_head("R3 odd parity error", 8'hE0, 1'b0, 1'b0, 1'b1);
        pop();
        parity_mode = 3'b101;
        send(8'h0F, 1'b1, 2'b11);
        expect_head("R3 forced-1 parity error", 8'h0F, 1'b0, 1'b0, 1'b1);
        pop();
        parity_mode = 3'b000;
        chk("R8 err_any clear after pop", 32'(err_any), 32'd0);

        // R4 stop length handling
        stop_half = 3'd4;
        send(8'hC3, 1'b0, 2'b10);
        expect_head("R4 second stop low", 8'hC3, 1'b0, 1'b1, 1'b0);
        pop();
        send(8'hC3, 1'b0, 2'b11);
        expect_head("R4 two good stops", 8'hC3, 1'b0, 1'b0, 1'b0);
        pop();
        stop_half = 3'd3;
        send(8'h3C, 1'b0, 2'b11);
        expect_head("R4 one and a half stops", 8'h3C, 1'b0, 1'b0, 1'b0);
        pop();
        stop_half = 3'd2;
        send(8'h81, 1'b0, 2'b00);
        expect_head("R4 stop low framing", 8'h81, 1'b0, 1'b1, 1'b0);
        pop();

        // R5 break
        send(8'h00, 1'b0, 2'b00);
        expect_head("R5 break", 8'h00, 1'b1, 1'b1, 1'b0);
        pop();

        // R6/R7 fill, overrun, order
        send(8'h11, 1'b0, 2'b11);
        send(8'h22, 1'b0, 2'b11);
        send(8'h33, 1'b0, 2'b11);
        send(8'h44, 1'b0, 2'b11);
        chk("R6 full at depth", {30'd0, q_full, err_overrun}, {30'd0, 2'b10});
        chk("R6 count at depth", 32'(q_count), 32'(DEPTH));
        send(8'h55, 1'b0, 2'b11);
        chk("R7 overrun set", 32'(err_overrun), 32'd1);
        chk("R7 count unchanged", 32'(q_count), 32'(DEPTH));
        expect_head("R6 order 0", 8'h11, 1'b0, 1'b0, 1'b0); pop();
        expect_head("R6 order 1", 8'h22, 1'b0, 1'b0, 1'b0); pop();
        expect_head("R6 order 2", 8'h33, 1'b0, 1'b0, 1'b0); pop();
        expect_head("R6 order 3", 8'h44, 1'b0, 1'b0, 1'b0); pop();
        chk("R6 empty after drain", 32'(q_empty), 32'd1);
        pop();
        chk("R6 pop on empty", 32'(q_count), 32'd0);
        chk("R7 overrun sticky", 32'(err_overrun), 32'd1);
        clear_q();
        chk("R11 clear overrun", {30'd0, err_overrun, q_empty}, {30'd0, 2'b01});

        // R8 error char hidden behind a good one
        parity_mode = 3'b011;
        send(8'h5A, 1'b0, 2'b11);
        send(8'h6B, 1'b1, 2'b11);
        send(8'h7C, 1'b0, 2'b11);
        chk("R8 err_any with good head", {30'd0, err_any, err_parity}, {30'd0, 2'b10});
        pop();
        expect_head("R8 bad head", 8'h6B, 1'b0, 1'b0, 1'b1);
        pop();
        chk("R8 err_any drops", 32'(err_any), 32'd0);
        expect_head("R8 last good", 8'h7C, 1'b0, 1'b0, 1'b0);
        send(8'h01, 1'b1, 2'b11);
        chk("R11 before clear", 32'(err_any), 32'd1);
        clear_q();
        chk("R11 clear empties", {30'd0, q_empty, err_any}, {30'd0, 2'b10});
        parity_mode = 3'b000;

        // R9/R10 idle count and timeout
        word_len = 2'd0;
        send(8'h42, 1'b0, 2'b11);
        chk("R9 restart on char", 32'(idle_ticks < 48), 32'd1);
        chk("R10 no early timeout", 32'(char_timeout), 32'd0);
        found = 0; seen = 0;
        for (int c = 0; c < 4000 && !found; c++) begin
            @(negedge clk);
            if (char_timeout) begin found = 1; seen = int'(idle_ticks >> 4); end
        end
        chk("R10 threshold 8 bits", 32'(seen), 32'd44);
        pop();
        chk("R10 read clears timeout", 32'(char_timeout), 32'd0);
        chk("R9 read restarts idle", 32'(idle_ticks), 32'd0);

        word_len = 2'd3;
        send(8'h15, 1'b0, 2'b11);
        found = 0; seen = 0;
        for (int c = 0; c < 4000 && !found; c++) begin
            @(negedge clk);
            if (char_timeout) begin found = 1; seen = int'(idle_ticks >> 4); end
        end
        chk("R10 threshold 5 bits", 32'(seen), 32'd32);
        pop();
        word_len = 2'd0;

        repeat (9000) @(negedge clk);
        chk("R10 no timeout when empty", 32'(char_timeout), 32'd0);
        chk("R9 idle saturates", 32'(idle_ticks), 32'(12'hFFF));

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule